// File: doc/BRIEF.md
# Inbound Address Window Decoder

This block sits on the inbound side of a bus bridge. It turns each incoming 32-bit transaction address into a routing decision for the memory fabric behind the bridge. Software sets up a set of translation windows and one outer aperture through a simple write-only configuration port. For every request, the block first checks that the address falls inside the aperture. It then looks for an enabled window that covers the address. The result is the window index, a 4-bit target ID, an 8-bit attribute and a possibly remapped address. When no match is found, the result is a decode error.

Requests arrive on a valid/ready stream, and results leave on another one. Between them sits a single output register. A request is accepted when `req_valid` and `req_ready` are both high at a rising clock edge. Its result appears on the `rsp_*` pins after that edge. The result stays there, unchanged, until `rsp_ready` is seen high at an edge. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. So a stalled consumer stops new requests from being accepted, and a full-rate consumer sees one result per cycle. A configuration write takes effect for requests accepted on later edges.

Top module: `iwin_decoder`

## Requirements
- R1: After reset, every window and the aperture are disabled and `rsp_valid` is low. A request issued with no configuration written returns `rsp_err`=1.
- R2: Window n (n = 0..4) has its control register at 0x1820+16n, its base at 0x1824+16n and its remap at 0x182C+16n. Window 5 uses 0x1880, 0x1884 and 0x188C. The aperture control is at 0x1804, the aperture low base at 0x0018 and the aperture high base at 0x001C. A write occurs when `cfg_we` is high at a clock edge.
- R3: The window control word fields are:
  - bits [31:16]: size in 64 KB units, minus one
  - bits [15:8]: attribute
  - bits [7:4]: target ID
  - bit 0: enable
- R4: Window base and aperture low base registers keep only bits [31:16]. The lower 16 bits written are discarded.
- R5: The aperture control word holds size−1 (64 KB units) in bits [31:16] and an enable in bit 0; the size is a power of two. An address outside an enabled aperture gives `rsp_err`=1, even if a window matches. A non-zero aperture high base also means no match.
- R6: Window n matches when it is enabled and `(addr & ~M) == (base & ~M)`, where M = {size field, 16'hFFFF}. The window's first and last bytes match; the byte one past the end does not.
- R7: When several windows match, the lowest-numbered one is reported.
- R8: On an error, `rsp_hit`=0, `rsp_err`=1, the index, target and attribute are 0, and `rsp_addr` equals the request address. On a hit, `rsp_hit`=1 and `rsp_err`=0.
- R9: On a hit, if the window's remap bits [31:16] are non-zero, `rsp_addr` = {remap[31:16], addr[15:0]}. Otherwise `rsp_addr` equals the request address.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and all `rsp_*` outputs hold their values. A result can be drained and a new request accepted at the same edge.
- R11: Writes to offsets not listed in R2 change no decode result.
- R12: Writing zero to a window control register disables that window, and lower-priority windows then take its addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 16 | Configuration register offset |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request address valid |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_addr | input | 32 | Inbound transaction address |
| rsp_valid | output | 1 | Decode result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | A window matched inside the aperture |
| rsp_err | output | 1 | Decode error: aperture or window miss |
| rsp_win | output | 3 | Index of the matching window |
| rsp_target | output | 4 | Target ID of the matching window |
| rsp_attr | output | 8 | Attribute byte of the matching window |
| rsp_addr | output | 32 | Translated or passed-through address |

## Verification
The decode is exercised with addresses in several positions:
- Inside a single window, which shows the target and attribute come from the right control word.
- In a region where two windows overlap, which checks the priority order.
- On the first and last byte of a window and one past its end, which checks how the size mask is formed.
- In a window with a remap value, which shows the upper half is replaced while the low 16 bits are kept.

Some addresses match a window but fall outside the aperture, or match only a disabled window. These separate the aperture gate from the window enable. A write to an unmapped offset shows that stray writes change nothing. A stalled consumer, held while a second request waits, shows that the result stays put and that the drain and the next acceptance can happen at the same edge.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
  localparam int CFG_AW    = 16;
  localparam int DATA_W    = 32;
  localparam int GRAN_W    = 16;
  localparam int HI_W      = DATA_W - GRAN_W;
  localparam int TGT_W     = 4;
  localparam int ATTR_W    = 8;
  localparam int MAX_WIN   = 6;
  localparam int WIN_IDX_W = $clog2(MAX_WIN);

  localparam logic [CFG_AW-1:0] AP_CTRL_OFF = 16'h1804;
  localparam logic [CFG_AW-1:0] AP_LO_OFF   = 16'h0018;
  localparam logic [CFG_AW-1:0] AP_HI_OFF   = 16'h001C;

  typedef struct packed {
    logic              en;
    logic [HI_W-1:0]   size_m1;
    logic [ATTR_W-1:0] attr;
    logic [TGT_W-1:0]  tgt;
    logic [HI_W-1:0]   base_hi;
    logic [HI_W-1:0]   remap_hi;
  } win_cfg_t;

  typedef struct packed {
    logic              en;
    logic [HI_W-1:0]   size_m1;
    logic [HI_W-1:0]   base_hi;
    logic [DATA_W-1:0] base_upper;
  } ap_cfg_t;

  typedef struct packed {
    logic                 hit;
    logic                 err;
    logic [WIN_IDX_W-1:0] win;
    logic [TGT_W-1:0]     tgt;
    logic [ATTR_W-1:0]    attr;
    logic [DATA_W-1:0]    addr;
  } rsp_t;

  // Control word offset for window n; the last window sits apart from the strided group.
  function automatic logic [CFG_AW-1:0] win_ctrl_off(input int n);
    if (n < 5) return CFG_AW'(16'h1820 + 16 * n);
    else       return 16'h1880;
  endfunction

  function automatic logic [CFG_AW-1:0] win_base_off(input int n);
    return win_ctrl_off(n) + 16'h0004;
  endfunction

  function automatic logic [CFG_AW-1:0] win_remap_off(input int n);
    return win_ctrl_off(n) + 16'h000C;
  endfunction
endpackage

// File: rtl/iwin_regs.sv
module iwin_regs
  import iwin_pkg::*;
#(
  parameter int NUM_WIN = MAX_WIN
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [DATA_W-1:0]           cfg_wdata,
  output win_cfg_t [NUM_WIN-1:0]      win_cfg,
  output ap_cfg_t                     ap_cfg
);
  // Per-window register triplets.
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    localparam logic [CFG_AW-1:0] CTRL_OFF  = win_ctrl_off(i);
    localparam logic [CFG_AW-1:0] BASE_OFF  = win_base_off(i);
    localparam logic [CFG_AW-1:0] REMAP_OFF = win_remap_off(i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_cfg[i] <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == CTRL_OFF) begin
          win_cfg[i].size_m1 <= cfg_wdata[31:16];
          win_cfg[i].attr    <= cfg_wdata[15:8];
          win_cfg[i].tgt     <= cfg_wdata[7:4];
          win_cfg[i].en      <= cfg_wdata[0];
        end
        if (cfg_addr == BASE_OFF)  win_cfg[i].base_hi  <= cfg_wdata[31:16];
        if (cfg_addr == REMAP_OFF) win_cfg[i].remap_hi <= cfg_wdata[31:16];
      end
    end
  end

  // Outer aperture registers.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ap_cfg <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == AP_CTRL_OFF) begin
        ap_cfg.size_m1 <= cfg_wdata[31:16];
        ap_cfg.en      <= cfg_wdata[0];
      end
      if (cfg_addr == AP_LO_OFF) ap_cfg.base_hi    <= cfg_wdata[31:16];
      if (cfg_addr == AP_HI_OFF) ap_cfg.base_upper <= cfg_wdata;
    end
  end
endmodule

// File: rtl/iwin_match.sv
module iwin_match
  import iwin_pkg::*;
#(
  parameter int NUM_WIN = MAX_WIN
) (
  input  logic [DATA_W-1:0]      addr,
  input  win_cfg_t [NUM_WIN-1:0] win_cfg,
  input  ap_cfg_t                ap_cfg,
  output logic                   ap_hit,
  output logic [NUM_WIN-1:0]     win_hit
);
  localparam logic [GRAN_W-1:0] LOW_ONES = '1;

  logic [DATA_W-1:0] ap_mask;
  assign ap_mask = {ap_cfg.size_m1, LOW_ONES};
  assign ap_hit  = ap_cfg.en && (ap_cfg.base_upper == '0) &&
                   ((addr & ~ap_mask) == ({ap_cfg.base_hi, {GRAN_W{1'b0}}} & ~ap_mask));

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    logic [DATA_W-1:0] mask;
    assign mask       = {win_cfg[i].size_m1, LOW_ONES};
    assign win_hit[i] = win_cfg[i].en &&
                        ((addr & ~mask) == ({win_cfg[i].base_hi, {GRAN_W{1'b0}}} & ~mask));
  end
endmodule

// File: rtl/iwin_prio.sv
module iwin_prio #(
  parameter int N     = 6,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  // Scan from the top down so the lowest set bit is written last and wins.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/iwin_decoder.sv
module iwin_decoder
  import iwin_pkg::*;
#(
  parameter int NUM_WIN = MAX_WIN
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_hit,
  output logic        rsp_err,
  output logic [2:0]  rsp_win,
  output logic [3:0]  rsp_target,
  output logic [7:0]  rsp_attr,
  output logic [31:0] rsp_addr
);
  win_cfg_t [NUM_WIN-1:0] win_cfg;
  ap_cfg_t                ap_cfg;
  logic                   ap_hit;
  logic [NUM_WIN-1:0]     win_hit;
  logic                   any_hit;
  logic [WIN_IDX_W-1:0]   sel;

  iwin_regs #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .win_cfg   (win_cfg),
    .ap_cfg    (ap_cfg)
  );

  iwin_match #(.NUM_WIN(NUM_WIN)) u_match (
    .addr    (req_addr),
    .win_cfg (win_cfg),
    .ap_cfg  (ap_cfg),
    .ap_hit  (ap_hit),
    .win_hit (win_hit)
  );

  iwin_prio #(.N(NUM_WIN), .IDX_W(WIN_IDX_W)) u_prio (
    .req (win_hit & {NUM_WIN{ap_hit}}),
    .any (any_hit),
    .idx (sel)
  );

  // Fields of the selected window.
  logic [TGT_W-1:0]  sel_tgt;
  logic [ATTR_W-1:0] sel_attr;
  logic [HI_W-1:0]   sel_remap;
  always_comb begin
    sel_tgt   = '0;
    sel_attr  = '0;
    sel_remap = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (sel == WIN_IDX_W'(i)) begin
        sel_tgt   = win_cfg[i].tgt;
        sel_attr  = win_cfg[i].attr;
        sel_remap = win_cfg[i].remap_hi;
      end
    end
  end

  rsp_t nxt, rsp_q;
  always_comb begin
    nxt      = '0;
    nxt.addr = req_addr;
    if (any_hit) begin
      nxt.hit  = 1'b1;
      nxt.win  = sel;
      nxt.tgt  = sel_tgt;
      nxt.attr = sel_attr;
      if (sel_remap != '0) nxt.addr = {sel_remap, req_addr[GRAN_W-1:0]};
    end else begin
      nxt.err = 1'b1;
    end
  end

  // One-entry output stage.
  logic accept;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_q     <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_q     <= nxt;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_hit    = rsp_q.hit;
  assign rsp_err    = rsp_q.err;
  assign rsp_win    = rsp_q.win;
  assign rsp_target = rsp_q.tgt;
  assign rsp_attr   = rsp_q.attr;
  assign rsp_addr   = rsp_q.addr;
endmodule

// File: rtl/iwin_decoder_chk.sv
module iwin_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_hit,
  input logic        rsp_err,
  input logic [2:0]  rsp_win,
  input logic [3:0]  rsp_target,
  input logic [7:0]  rsp_attr,
  input logic [31:0] rsp_addr
);
  logic [31:0] acc_addr;
  always_ff @(posedge clk) begin
    if (!rst_n)                      acc_addr <= '0;
    else if (req_valid && req_ready) acc_addr <= req_addr;
  end

  // R10: a stalled result holds still and blocks new requests
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_hit) &&
                                $stable(rsp_err) && $stable(rsp_win) && $stable(rsp_target) &&
                                $stable(rsp_attr));

  a_r10_block: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R8: a valid result is exactly one of hit or error
  a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_err}) == 1);

  // R8: an error carries no target
  a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_win == 3'd0 && rsp_target == 4'd0 && rsp_attr == 8'd0 &&
                             rsp_addr == acc_addr);

  // R9: the low 64 KB offset always survives translation
  a_r9_low: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_addr[15:0] == acc_addr[15:0]);

  // R1: a result appears only after an accepted request
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));
endmodule

bind iwin_decoder iwin_decoder_chk u_chk (.*);

// File: tb/sim_iwin_decoder.sv
module sim_iwin_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit, rsp_err;
  logic [2:0]  rsp_win;
  logic [3:0]  rsp_target;
  logic [7:0]  rsp_attr;
  logic [31:0] rsp_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  iwin_decoder u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic hit, input logic [2:0] win,
                            input logic [3:0] tgt, input logic [7:0] attr, input logic [31:0] oa);
    chk({req, " valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " hit"},   32'(rsp_hit), 32'(hit));
    chk({req, " err"},   32'(rsp_err), 32'(!hit));
    chk({req, " win"},   32'(rsp_win), 32'(win));
    chk({req, " tgt"},   32'(rsp_target), 32'(tgt));
    chk({req, " attr"},  32'(rsp_attr), 32'(attr));
    chk({req, " addr"},  rsp_addr, oa);
  endtask

  // {addr, hit, win, tgt, attr, out_addr}
  localparam int NV = 10;
  localparam logic [79:0] VEC [NV] = '{
    {32'h0000_1000, 1'b1, 3'd0, 4'h3, 8'hAA, 32'h0000_1000},  // R3 R6 inside w0
    {32'h0080_1234, 1'b1, 3'd0, 4'h3, 8'hAA, 32'h0080_1234},  // R7 overlap w0/w1
    {32'h00FF_FFFF, 1'b1, 3'd0, 4'h3, 8'hAA, 32'h00FF_FFFF},  // R6 last byte
    {32'h0100_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'h0100_0000},  // R6 one past end
    {32'h0123_ABCD, 1'b1, 3'd2, 4'h7, 8'hCC, 32'h8765_ABCD},  // R4 R9 remap
    {32'h0123_FFFF, 1'b1, 3'd2, 4'h7, 8'hCC, 32'h8765_FFFF},  // R9 last byte
    {32'h0124_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'h0124_0000},  // R6 past 64 KB
    {32'h0200_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'h0200_0000},  // R3 disabled w3
    {32'h0500_0000, 1'b1, 3'd5, 4'h2, 8'hEE, 32'h0500_0000},  // R2 sixth window
    {32'h1000_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'h1000_0000}   // R5 aperture miss
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1 req_ready after reset", 32'(req_ready), 32'd1);
    send(32'h0000_1000);
    expect_rsp("R1 unconfigured", 1'b0, 3'd0, 4'h0, 8'h00, 32'h0000_1000);

    // R2 R5 configuration
    wr(16'h1804, 32'h0FFF_0001);
    wr(16'h0018, 32'h0000_0000);
    wr(16'h001C, 32'h0000_0000);
    wr(16'h1824, 32'h0000_0000); wr(16'h182C, 32'h0);           wr(16'h1820, 32'h00FF_AA31);
    wr(16'h1834, 32'h0080_0000); wr(16'h183C, 32'h0);           wr(16'h1830, 32'h007F_BB51);
    wr(16'h1844, 32'h0123_4567); wr(16'h184C, 32'h8765_4321);   wr(16'h1840, 32'h0000_CC71);
    wr(16'h1854, 32'h0200_0000);                                 wr(16'h1850, 32'h0FFF_DD90);
    wr(16'h1864, 32'h1000_0000);                                 wr(16'h1860, 32'h00FF_1141);
    wr(16'h1884, 32'h0400_0000); wr(16'h188C, 32'h0);           wr(16'h1880, 32'h03FF_EE21);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][79:48]);
      expect_rsp($sformatf("vec%0d", i), VEC[i][47], VEC[i][46:44], VEC[i][43:40],
                 VEC[i][39:32], VEC[i][31:0]);
    end

    // R11 stray writes
    wr(16'h1828, 32'hFFFF_FFF1);
    wr(16'h1890, 32'hFFFF_FFF1);
    wr(16'h1800, 32'hFFFF_FFFF);
    send(32'h0200_0000);
    expect_rsp("R11 unmapped write", 1'b0, 3'd0, 4'h0, 8'h00, 32'h0200_0000);
    send(32'h0000_1000);
    expect_rsp("R11 w0 intact", 1'b1, 3'd0, 4'h3, 8'hAA, 32'h0000_1000);

    // R5 nonzero aperture high base
    wr(16'h001C, 32'h0000_0001);
    send(32'h0000_1000);
    expect_rsp("R5 high base", 1'b0, 3'd0, 4'h0, 8'h00, 32'h0000_1000);
    wr(16'h001C, 32'h0000_0000);

    // R12 disable w0, w1 takes over
    wr(16'h1820, 32'h0000_0000);
    send(32'h0080_1234);
    expect_rsp("R12 w1 takes over", 1'b1, 3'd1, 4'h5, 8'hBB, 32'h0080_1234);
    send(32'h0000_1000);
    expect_rsp("R12 w0 disabled", 1'b0, 3'd0, 4'h0, 8'h00, 32'h0000_1000);

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h0080_0010;
    @(negedge clk);
    req_addr = 32'h0500_0004;
    chk("R10 req_ready low when stalled", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk("R10 held win", 32'(rsp_win), 32'd1);
    chk("R10 held addr", rsp_addr, 32'h0080_0010);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R10 next after drain", 1'b1, 3'd5, 4'h2, 8'hEE, 32'h0500_0004);
    @(negedge clk);
    chk("R10 drained", 32'(rsp_valid), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule